// File: doc/BRIEF.md
# Frame-Count Display Timing Generator

This block produces horizontal sync, vertical sync, data-enable and 24-bit RGB for an external television-style display link, all from one pixel clock. Horizontal position comes from a line counter. Vertical position does not come from a line counter: one frame counter counts every pixel clock in the frame. The vertical sync length and the vertical display window are therefore given in pixel clocks, counted from the start of the vertical sync pulse.

Software-style configuration inputs set the following:
- the line length and the horizontal pulse width;
- the frame length and the vertical pulse length;
- both display windows;
- a skew that shifts the vertical window;
- the two sync polarities;
- an enable bit;
- an underflow fill colour.

The generator copies all of these into a shadow set while it is idle, and at the last pixel of each frame. A disable, or any other change, therefore takes effect only when a frame starts. A pixel stream with a valid flag feeds the RGB output. A missing pixel inside the display area is replaced by the fill colour and is recorded in a sticky flag.

Top module: `tv_timing_gen`

## Requirements
- R1: While enabled, the line counter steps once per clock and wraps to 0 after line length minus 1. The frame counter also steps once per clock and wraps to 0 after frame length minus 1. While disabled, both counters are held at 0.
- R2: The horizontal sync is active during line positions 0 to pulse width minus 1.
- R3: The vertical sync is active during frame positions 0 to vertical pulse length minus 1, counted in pixel clocks.
- R4: Each sync is active high when its polarity bit is 0 and active low when the bit is 1. While disabled, each sync sits at its inactive level.
- R5: Data-enable is 1 only when the generator is enabled and both of the following hold:
  - the line position lies in the inclusive range [hstart, hend];
  - the frame position lies in the inclusive range [vstart+skew, vend+skew].
- R6: All configuration inputs, including the enable bit, are copied into the shadow set in either of two cases:
  - on every clock while disabled;
  - on the clock where the frame counter is at its last position.
  At all other times the shadow set does not change.
- R7: The RGB output takes one of three values:
  - the input pixel when data-enable is 1 and the pixel is valid;
  - the shadowed fill colour when data-enable is 1 and the pixel is not valid;
  - 0 when data-enable is 0.
- R8: The underflow flag sets on any clock where data-enable is 1 and the pixel is not valid. It stays set until reset.
- R9: Every output is registered and reflects the counter positions and pixel inputs of the previous clock.
- R10: After reset, every output is 0 and the generator is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Run request |
| cfg_line_len | input | HW | Pixels per line |
| cfg_hpulse | input | HW | Horizontal pulse width |
| cfg_frame_len | input | FW | Pixel clocks per frame |
| cfg_vpulse | input | FW | Vertical pulse length in pixel clocks |
| cfg_hwin_lo | input | HW | First display pixel of a line |
| cfg_hwin_hi | input | HW | Last display pixel of a line |
| cfg_vwin_lo | input | FW | First display clock of a frame |
| cfg_vwin_hi | input | FW | Last display clock of a frame |
| cfg_skew | input | HW | Offset added to the vertical window |
| cfg_hs_low | input | 1 | Horizontal sync active low |
| cfg_vs_low | input | 1 | Vertical sync active low |
| cfg_fill_rgb | input | 24 | Underflow fill colour |
| pix_valid | input | 1 | Input pixel present |
| pix_rgb | input | 24 | Input pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgb | output | 24 | Output pixel |
| underflow | output | 1 | Sticky underflow flag |

## Verification
A wrong counter or shadow value shows up as a misplaced sync or data-enable edge. Because the outputs are registered, this appears on the clock right after the wrong internal value. A missed or early configuration latch changes sync polarity or window placement exactly at a frame boundary. The bench therefore compares every output on every clock, across a reconfiguration, a disable and a re-enable issued in the middle of a frame. A fill-colour or flag fault becomes visible on the first data-enable clock that has no valid pixel.

// File: rtl/tg_pkg.sv
package tg_pkg;
  // Inclusive window test on zero-extended positions.
  function automatic logic tg_in_range(input logic [31:0] pos,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi);
    return (pos >= lo) && (pos <= hi);
  endfunction

  // Pulse covering positions 0 .. len-1.
  function automatic logic tg_pulse(input logic [31:0] pos,
                                    input logic [31:0] len);
    return pos < len;
  endfunction

  // Map an active flag to a pin level.
  function automatic logic tg_level(input logic active, input logic low);
    return active ^ low;
  endfunction

  // Next value of a wrapping counter.
  function automatic logic [31:0] tg_step(input logic [31:0] pos,
                                          input logic [31:0] len);
    return (pos + 32'd1 >= len) ? 32'd0 : pos + 32'd1;
  endfunction
endpackage

// File: rtl/tg_shadow_cfg.sv
module tg_shadow_cfg #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_last,
  input  logic          cfg_enable,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [HW-1:0] cfg_hpulse,
  input  logic [FW-1:0] cfg_frame_len,
  input  logic [FW-1:0] cfg_vpulse,
  input  logic [HW-1:0] cfg_hwin_lo,
  input  logic [HW-1:0] cfg_hwin_hi,
  input  logic [FW-1:0] cfg_vwin_lo,
  input  logic [FW-1:0] cfg_vwin_hi,
  input  logic [HW-1:0] cfg_skew,
  input  logic          cfg_hs_low,
  input  logic          cfg_vs_low,
  input  logic [23:0]   cfg_fill_rgb,
  output logic          run,
  output logic [HW-1:0] s_line_len,
  output logic [HW-1:0] s_hpulse,
  output logic [FW-1:0] s_frame_len,
  output logic [FW-1:0] s_vpulse,
  output logic [HW-1:0] s_hwin_lo,
  output logic [HW-1:0] s_hwin_hi,
  output logic [FW-1:0] s_vwin_lo,
  output logic [FW-1:0] s_vwin_hi,
  output logic [HW-1:0] s_skew,
  output logic          s_hs_low,
  output logic          s_vs_low,
  output logic [23:0]   s_fill_rgb,
  output logic          load_evt
);
  assign load_evt = !run || frame_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run         <= 1'b0;
      s_line_len  <= '0;
      s_hpulse    <= '0;
      s_frame_len <= '0;
      s_vpulse    <= '0;
      s_hwin_lo   <= '0;
      s_hwin_hi   <= '0;
      s_vwin_lo   <= '0;
      s_vwin_hi   <= '0;
      s_skew      <= '0;
      s_hs_low    <= 1'b0;
      s_vs_low    <= 1'b0;
      s_fill_rgb  <= '0;
    end else if (load_evt) begin
      run         <= cfg_enable;
      s_line_len  <= cfg_line_len;
      s_hpulse    <= cfg_hpulse;
      s_frame_len <= cfg_frame_len;
      s_vpulse    <= cfg_vpulse;
      s_hwin_lo   <= cfg_hwin_lo;
      s_hwin_hi   <= cfg_hwin_hi;
      s_vwin_lo   <= cfg_vwin_lo;
      s_vwin_hi   <= cfg_vwin_hi;
      s_skew      <= cfg_skew;
      s_hs_low    <= cfg_hs_low;
      s_vs_low    <= cfg_vs_low;
      s_fill_rgb  <= cfg_fill_rgb;
    end
  end

  // R6: the shadow set holds between frame boundaries while running
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_last) |=> ($stable(s_frame_len) && $stable(s_line_len)
                              && $stable(s_hs_low) && $stable(s_vs_low) && run));
endmodule

// File: rtl/tg_counters.sv
module tg_counters #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] line_len,
  input  logic [FW-1:0] frame_len,
  output logic [HW-1:0] hpos,
  output logic [FW-1:0] fpos,
  output logic          line_last,
  output logic          frame_last
);
  import tg_pkg::*;

  assign line_last  = run && (32'(hpos) + 32'd1 >= 32'(line_len));
  assign frame_last = run && (32'(fpos) + 32'd1 >= 32'(frame_len));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hpos <= '0;
      fpos <= '0;
    end else begin
      hpos <= HW'(tg_step(32'(hpos), 32'(line_len)));
      fpos <= FW'(tg_step(32'(fpos), 32'(frame_len)));
    end
  end

  // R1: counters return to zero after their last position
  p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |=> (hpos == '0));
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> (fpos == '0));
  // R1: counters held at zero while idle
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hpos == '0 && fpos == '0));
endmodule

// File: rtl/tg_pixel_stage.sv
module tg_pixel_stage #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] hpos,
  input  logic [FW-1:0] fpos,
  input  logic [HW-1:0] hpulse,
  input  logic [FW-1:0] vpulse,
  input  logic [HW-1:0] hwin_lo,
  input  logic [HW-1:0] hwin_hi,
  input  logic [FW-1:0] vwin_lo,
  input  logic [FW-1:0] vwin_hi,
  input  logic [HW-1:0] skew,
  input  logic          hs_low,
  input  logic          vs_low,
  input  logic [23:0]   fill_rgb,
  input  logic          pix_valid,
  input  logic [23:0]   pix_rgb,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [23:0]   rgb,
  output logic          underflow,
  output logic          starve_evt
);
  import tg_pkg::*;

  logic in_h, in_v, de_next, hs_act, vs_act;

  always_comb begin
    in_h    = tg_in_range(32'(hpos), 32'(hwin_lo), 32'(hwin_hi));
    in_v    = tg_in_range(32'(fpos), 32'(vwin_lo) + 32'(skew),
                          32'(vwin_hi) + 32'(skew));
    de_next = run && in_h && in_v;
    hs_act  = run && tg_pulse(32'(hpos), 32'(hpulse));
    vs_act  = run && tg_pulse(32'(fpos), 32'(vpulse));
  end

  assign starve_evt = de_next && !pix_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      de        <= 1'b0;
      rgb       <= '0;
      underflow <= 1'b0;
    end else begin
      hsync <= tg_level(hs_act, hs_low);
      vsync <= tg_level(vs_act, vs_low);
      de    <= de_next;
      if (!de_next)       rgb <= '0;
      else if (pix_valid) rgb <= pix_rgb;
      else                rgb <= fill_rgb;
      if (starve_evt) underflow <= 1'b1;
    end
  end

  // R8: the flag never clears outside reset
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R8: a starved display clock raises the flag
  p_flag_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    starve_evt |=> underflow);
  // R7: blank clocks carry zero colour
  p_blank_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (rgb == '0));
  // R5: data-enable needs a running generator on the previous clock
  p_de_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> $past(run));
endmodule

// File: rtl/tv_timing_gen.sv
module tv_timing_gen #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [HW-1:0] cfg_hpulse,
  input  logic [FW-1:0] cfg_frame_len,
  input  logic [FW-1:0] cfg_vpulse,
  input  logic [HW-1:0] cfg_hwin_lo,
  input  logic [HW-1:0] cfg_hwin_hi,
  input  logic [FW-1:0] cfg_vwin_lo,
  input  logic [FW-1:0] cfg_vwin_hi,
  input  logic [HW-1:0] cfg_skew,
  input  logic          cfg_hs_low,
  input  logic          cfg_vs_low,
  input  logic [23:0]   cfg_fill_rgb,
  input  logic          pix_valid,
  input  logic [23:0]   pix_rgb,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [23:0]   rgb,
  output logic          underflow
);
  logic          run, load_evt, line_last, frame_last, starve_evt;
  logic [HW-1:0] s_line_len, s_hpulse, s_hwin_lo, s_hwin_hi, s_skew;
  logic [FW-1:0] s_frame_len, s_vpulse, s_vwin_lo, s_vwin_hi;
  logic          s_hs_low, s_vs_low;
  logic [23:0]   s_fill_rgb;
  logic [HW-1:0] hpos;
  logic [FW-1:0] fpos;

  tg_shadow_cfg #(.HW(HW), .FW(FW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_last(frame_last),
    .cfg_enable(cfg_enable), .cfg_line_len(cfg_line_len),
    .cfg_hpulse(cfg_hpulse), .cfg_frame_len(cfg_frame_len),
    .cfg_vpulse(cfg_vpulse), .cfg_hwin_lo(cfg_hwin_lo),
    .cfg_hwin_hi(cfg_hwin_hi), .cfg_vwin_lo(cfg_vwin_lo),
    .cfg_vwin_hi(cfg_vwin_hi), .cfg_skew(cfg_skew),
    .cfg_hs_low(cfg_hs_low), .cfg_vs_low(cfg_vs_low),
    .cfg_fill_rgb(cfg_fill_rgb), .run(run),
    .s_line_len(s_line_len), .s_hpulse(s_hpulse),
    .s_frame_len(s_frame_len), .s_vpulse(s_vpulse),
    .s_hwin_lo(s_hwin_lo), .s_hwin_hi(s_hwin_hi),
    .s_vwin_lo(s_vwin_lo), .s_vwin_hi(s_vwin_hi), .s_skew(s_skew),
    .s_hs_low(s_hs_low), .s_vs_low(s_vs_low), .s_fill_rgb(s_fill_rgb),
    .load_evt(load_evt)
  );

  tg_counters #(.HW(HW), .FW(FW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run),
    .line_len(s_line_len), .frame_len(s_frame_len),
    .hpos(hpos), .fpos(fpos),
    .line_last(line_last), .frame_last(frame_last)
  );

  tg_pixel_stage #(.HW(HW), .FW(FW)) u_pix (
    .clk(clk), .rst_n(rst_n), .run(run), .hpos(hpos), .fpos(fpos),
    .hpulse(s_hpulse), .vpulse(s_vpulse),
    .hwin_lo(s_hwin_lo), .hwin_hi(s_hwin_hi),
    .vwin_lo(s_vwin_lo), .vwin_hi(s_vwin_hi), .skew(s_skew),
    .hs_low(s_hs_low), .vs_low(s_vs_low), .fill_rgb(s_fill_rgb),
    .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb),
    .underflow(underflow), .starve_evt(starve_evt)
  );

  // R6: a running generator leaves run state only at a frame boundary
  p_stop_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_evt) |=> run);
  // R1: a line wrap never happens while idle
  p_wrap_only_running_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |-> run);
endmodule

// File: tb/tv_timing_gen_tb.sv
module tv_timing_gen_tb;
  localparam int HW = 12;
  localparam int FW = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cfg_enable;
  logic [HW-1:0] cfg_line_len, cfg_hpulse, cfg_hwin_lo, cfg_hwin_hi, cfg_skew;
  logic [FW-1:0] cfg_frame_len, cfg_vpulse, cfg_vwin_lo, cfg_vwin_hi;
  logic          cfg_hs_low, cfg_vs_low;
  logic [23:0]   cfg_fill_rgb;
  logic          pix_valid;
  logic [23:0]   pix_rgb;
  logic          hsync, vsync, de, underflow;
  logic [23:0]   rgb;

  tv_timing_gen #(.HW(HW), .FW(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_line_len(cfg_line_len), .cfg_hpulse(cfg_hpulse),
    .cfg_frame_len(cfg_frame_len), .cfg_vpulse(cfg_vpulse),
    .cfg_hwin_lo(cfg_hwin_lo), .cfg_hwin_hi(cfg_hwin_hi),
    .cfg_vwin_lo(cfg_vwin_lo), .cfg_vwin_hi(cfg_vwin_hi),
    .cfg_skew(cfg_skew), .cfg_hs_low(cfg_hs_low), .cfg_vs_low(cfg_vs_low),
    .cfg_fill_rgb(cfg_fill_rgb), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb), .underflow(underflow)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  // Reference state, built from the requirement text
  bit m_run;
  int m_h, m_f;
  int s_len, s_hp, s_flen, s_vp, s_hlo, s_hhi, s_vlo, s_vhi, s_sk;
  bit s_hsl, s_vsl;
  bit [23:0] s_fill;
  bit e_hs, e_vs, e_de, e_uf;
  bit [23:0] e_rgb;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic model_step();
    bit hin, vin, fend;
    hin  = (m_h >= s_hlo) && (m_h <= s_hhi);
    vin  = (m_f >= s_vlo + s_sk) && (m_f <= s_vhi + s_sk);
    e_de = m_run && hin && vin;
    e_hs = (m_run && (m_h < s_hp)) ? !s_hsl : s_hsl;
    e_vs = (m_run && (m_f < s_vp)) ? !s_vsl : s_vsl;
    e_rgb = !e_de ? 24'h0 : (pix_valid ? pix_rgb : s_fill);
    if (e_de && !pix_valid) e_uf = 1'b1;
    fend = m_run && (m_f == s_flen - 1);
    if (!m_run) begin
      m_h = 0; m_f = 0;
    end else begin
      m_h = (m_h + 1 >= s_len)  ? 0 : m_h + 1;
      m_f = (m_f + 1 >= s_flen) ? 0 : m_f + 1;
    end
    if (!m_run || fend) begin
      m_run = cfg_enable;
      s_len = int'(cfg_line_len); s_hp = int'(cfg_hpulse);
      s_flen = int'(cfg_frame_len); s_vp = int'(cfg_vpulse);
      s_hlo = int'(cfg_hwin_lo); s_hhi = int'(cfg_hwin_hi);
      s_vlo = int'(cfg_vwin_lo); s_vhi = int'(cfg_vwin_hi);
      s_sk = int'(cfg_skew); s_hsl = cfg_hs_low; s_vsl = cfg_vs_low;
      s_fill = cfg_fill_rgb;
    end
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      pix_valid = ((cyc % 11) != 5);
      pix_rgb   = {8'(cyc), 8'(cyc * 3), 8'hA5};
      model_step();
      @(negedge clk);
      cyc++;
      // R1 R9: counter placement shows in sync and window timing one clock later
      chk("R1 R2 R4 R9", "hsync", int'(hsync), int'(e_hs));
      chk("R1 R3 R4 R9", "vsync", int'(vsync), int'(e_vs));
      chk("R5 R6", "de", int'(de), int'(e_de));
      chk("R7", "rgb", int'(rgb), int'(e_rgb));
      chk("R8", "underflow", int'(underflow), int'(e_uf));
    end
  endtask

  task automatic cfg_a(input bit en);
    cfg_enable = en; cfg_line_len = 10; cfg_hpulse = 2;
    cfg_frame_len = 60; cfg_vpulse = 10;
    cfg_hwin_lo = 4; cfg_hwin_hi = 8; cfg_vwin_lo = 20; cfg_vwin_hi = 49;
    cfg_skew = 0; cfg_hs_low = 0; cfg_vs_low = 0; cfg_fill_rgb = 24'hFFFFFF;
  endtask

  task automatic cfg_b();
    cfg_enable = 1; cfg_line_len = 8; cfg_hpulse = 3;
    cfg_frame_len = 40; cfg_vpulse = 8;
    cfg_hwin_lo = 3; cfg_hwin_hi = 6; cfg_vwin_lo = 12; cfg_vwin_hi = 31;
    cfg_skew = 3; cfg_hs_low = 1; cfg_vs_low = 1; cfg_fill_rgb = 24'h123456;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_valid = 1'b0; pix_rgb = '0;
    cfg_a(1'b0);
    repeat (4) @(negedge clk);
    // R10: reset state at the ports
    chk("R10", "hsync", int'(hsync), 0);
    chk("R10", "vsync", int'(vsync), 0);
    chk("R10", "de", int'(de), 0);
    chk("R10", "rgb", int'(rgb), 0);
    chk("R10", "underflow", int'(underflow), 0);
    rst_n = 1'b1;
    m_run = 0; m_h = 0; m_f = 0; e_uf = 0;
    s_len = 0; s_hp = 0; s_flen = 0; s_vp = 0; s_hlo = 0; s_hhi = 0;
    s_vlo = 0; s_vhi = 0; s_sk = 0; s_hsl = 0; s_vsl = 0; s_fill = 0;
    run_cycles(5);           // idle, outputs at inactive levels (R4)
    cfg_a(1'b1);
    run_cycles(150);         // two and a half frames of configuration A
    cfg_b();                 // R6: change in mid-frame, applies at frame end
    run_cycles(130);
    cfg_enable = 0;          // R6: disable waits for the frame boundary
    run_cycles(60);
    cfg_a(1'b1);             // re-enable, starts from zero (R1)
    run_cycles(130);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule